// File: doc/BRIEF.md
# Disk DMA Channel Register Front End

This block is the host-facing register set of one bus-master disk DMA channel. The host reaches it through an eight-byte window. It can read or write 1, 2 or 4 bytes starting at any byte offset. The window holds a command byte, a status byte and a 32-bit base address for the descriptor table. The block turns the host's use of the run bit into single-cycle requests to the DMA engine. A start request goes out when a transfer should begin. A cancel request goes out when the host stops one. A pointer-reload request tells the engine to return to the start of the descriptor table.

The device interrupt line passes straight through to the interrupt output. A rising edge on it is also recorded in the status byte, where the host clears it by writing a one. The engine reports completion on a done input, and that input clears the active flag. The descriptor walker and the disk device sit outside this block.

Window layout. Byte 0 is the command byte. Byte 2 is the status byte. Bytes 4 to 7 hold the base address, least significant byte first. Bytes 1 and 3 always read as zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the command byte, the status byte and the base address read as zero. The start, cancel and reload outputs are low, and the direction output is low.
- R2: A write to byte 0 stores only bit 0 (run) and bit 3 (direction). Every other bit of byte 0 reads back as zero. The direction output equals the stored bit 3.
- R3: A write to byte 0 whose bit 0 equals the stored run bit produces no start, cancel or reload pulse. It leaves the active flag unchanged.
- R4: A write that changes run from 1 to 0 raises cancel for exactly the one cycle after the write edge and clears the active flag (status bit 0).
- R5: A write that changes run from 0 to 1 raises reload for one cycle. If the active flag was clear, the same write also sets the active flag and raises start for that same cycle.
- R6: A high level on the engine done input clears the active flag at the next clock edge. If a run 0-to-1 write arrives in that same cycle, the write wins and the active flag ends up set.
- R7: The interrupt output always equals the device interrupt input. A 0-to-1 change of the device interrupt sets status bit 2. A steady level, high or low, does not set it.
- R8: Writing 1 to status bit 2 clears it. Writing 0 to bit 2 has no effect, and every other status bit ignores writes. When a rising interrupt and a clearing write fall in the same cycle, the bit ends up set.
- R9: A write to the base address replaces only the bytes it covers. Bits 1:0 of the base always read as zero.
- R10: A read returns window byte (offset+k) in data byte k and zeroes the bytes beyond the access width. Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. Bytes past offset 7 read as zero, and writes to them are dropped.
- R11: A single 4-byte write at offset 0 updates the command byte and the status byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Host write strobe, one cycle per write |
| acc_offset | input | 3 | Byte offset of the access in the window |
| acc_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| acc_wdata | input | 32 | Write data, byte 0 goes to the addressed offset |
| acc_rdata | output | 32 | Read data for the current offset and size (combinational) |
| eng_done | input | 1 | Engine reports the transfer finished; clears the active flag |
| dev_irq | input | 1 | Interrupt level from the disk device |
| irq_out | output | 1 | Interrupt passed through to the host |
| table_base | output | 32 | Descriptor table base address |
| dir_to_mem | output | 1 | Stored direction bit |
| start_pulse | output | 1 | One-cycle request to start a transfer |
| cancel_pulse | output | 1 | One-cycle request to abandon the transfer |
| ptr_reload | output | 1 | One-cycle request to reload the descriptor pointer from the base |

## Verification
The bench targets the following corner cases of the run bit and what a faulty design would do in each:
- Writing the run bit again with the value it already holds. A design that compares against the written value alone, rather than against the stored one, would raise a second start.
- A 1-to-0 run change that arrives in the same cycle as the done input. A design that mishandles this would leave the active flag set.

Base-address writes of one and two bytes at odd offsets are driven deliberately. A lane decoder that is wrong would corrupt the neighbouring bytes or let bits 1:0 become nonzero. Interrupt rises are placed against clearing writes in the same cycle, and a design that lets the write take priority would lose the event.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   localparam int unsigned CMD_BYTE  = 0;
   localparam int unsigned STS_BYTE  = 2;
   localparam int unsigned BASE_BYTE = 4;
   localparam int unsigned RUN_BIT   = 0;
   localparam int unsigned DIR_BIT   = 3;
   localparam int unsigned ACT_BIT   = 0;
   localparam int unsigned IRQ_BIT   = 2;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_BX = 2'd3
   } acc_size_e;

   function automatic int unsigned size_bytes(input logic [1:0] code);
      case (acc_size_e'(code))
         SZ_B1:   return 1;
         SZ_B2:   return 2;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/dma_lane_decode.sv
module dma_lane_decode #(
   parameter int unsigned WIN_BYTES = 8,
   parameter int unsigned ACC_BYTES = 4,
   localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
   localparam int unsigned WIN_W    = WIN_BYTES * 8
) (
   input  logic                   acc_wr,
   input  logic [OFF_W-1:0]       acc_offset,
   input  logic [1:0]             acc_size,
   input  logic [ACC_BYTES*8-1:0] acc_wdata,
   input  logic [WIN_W-1:0]       win_image,
   output logic [WIN_BYTES-1:0]   lane_we,
   output logic [WIN_W-1:0]       lane_wdata,
   output logic [ACC_BYTES*8-1:0] acc_rdata
);
   import dma_chan_pkg::*;

   initial begin
      if (WIN_W <= ACC_BYTES * 8)
         $error("dma_lane_decode: window must be wider than one access");
   end

   logic [OFF_W+2:0]       span_end;
   logic [WIN_W-1:0]       shifted_rd;
   logic [ACC_BYTES*8-1:0] width_mask;

   always_comb begin
      span_end = (OFF_W+3)'(acc_offset) + (OFF_W+3)'(size_bytes(acc_size));
   end

   for (genvar i = 0; i < WIN_BYTES; i++) begin : g_lane
      always_comb begin
         lane_we[i] = acc_wr && ((OFF_W+3)'(i) >= (OFF_W+3)'(acc_offset))
                             && ((OFF_W+3)'(i) <  span_end);
      end
   end

   always_comb begin
      lane_wdata = {{(WIN_W-ACC_BYTES*8){1'b0}}, acc_wdata} << (8 * acc_offset);
      shifted_rd = win_image >> (8 * acc_offset);
      width_mask = '0;
      for (int b = 0; b < ACC_BYTES; b++) begin
         if (b < int'(size_bytes(acc_size))) width_mask[8*b +: 8] = 8'hFF;
      end
      acc_rdata = shifted_rd[ACC_BYTES*8-1:0] & width_mask;
   end
endmodule

// File: rtl/dma_base_reg.sv
module dma_base_reg #(
   parameter int unsigned BASE_BYTES = 4,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [BASE_BYTES-1:0]   byte_we,
   input  logic [BASE_BYTES*8-1:0] byte_wdata,
   output logic [BASE_BYTES*8-1:0] base_q
);
   initial begin
      if (ALIGN_BITS > 7)
         $error("dma_base_reg: alignment must stay inside byte 0");
   end

   for (genvar b = 0; b < BASE_BYTES; b++) begin : g_byte
      if (b == 0 && ALIGN_BITS > 0) begin : g_aligned
         always_ff @(posedge clk) begin
            if (!rst_n)
               base_q[7:0] <= '0;
            else if (byte_we[0])
               base_q[7:0] <= {byte_wdata[7:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               base_q[8*b +: 8] <= '0;
            else if (byte_we[b])
               base_q[8*b +: 8] <= byte_wdata[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [7:0] cmd_wbyte,
   input  logic       sts_we,
   input  logic [7:0] sts_wbyte,
   input  logic       eng_done,
   input  logic       dev_irq,
   output logic       run_q,
   output logic       dir_q,
   output logic       active_q,
   output logic       irq_flag_q,
   output logic       start_pulse,
   output logic       cancel_pulse,
   output logic       ptr_reload
);
   import dma_chan_pkg::*;

   logic irq_prev_q;
   logic new_run, run_edge, irq_rise, irq_clear;

   always_comb begin
      new_run   = cmd_wbyte[RUN_BIT];
      run_edge  = cmd_we && (new_run != run_q);
      irq_rise  = dev_irq && !irq_prev_q;
      irq_clear = sts_we && sts_wbyte[IRQ_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q        <= 1'b0;
         dir_q        <= 1'b0;
         active_q     <= 1'b0;
         irq_flag_q   <= 1'b0;
         irq_prev_q   <= 1'b0;
         start_pulse  <= 1'b0;
         cancel_pulse <= 1'b0;
         ptr_reload   <= 1'b0;
      end else begin
         start_pulse  <= 1'b0;
         cancel_pulse <= 1'b0;
         ptr_reload   <= 1'b0;
         irq_prev_q   <= dev_irq;
         if (eng_done) active_q <= 1'b0;
         if (cmd_we) begin
            run_q <= new_run;
            dir_q <= cmd_wbyte[DIR_BIT];
         end
         if (run_edge) begin
            if (!new_run) begin
               cancel_pulse <= 1'b1;
               active_q     <= 1'b0;
            end else begin
               ptr_reload <= 1'b1;
               if (!active_q) begin
                  active_q    <= 1'b1;
                  start_pulse <= 1'b1;
               end
            end
         end
         if (irq_rise)       irq_flag_q <= 1'b1;
         else if (irq_clear) irq_flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int unsigned BASE_BYTES = 4,
   parameter int unsigned ALIGN_BITS = 2,
   localparam int unsigned WIN_BYTES = dma_chan_pkg::BASE_BYTE + BASE_BYTES,
   localparam int unsigned OFF_W     = $clog2(WIN_BYTES),
   localparam int unsigned BASE_W    = BASE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  logic [OFF_W-1:0]  acc_offset,
   input  logic [1:0]        acc_size,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   input  logic              eng_done,
   input  logic              dev_irq,
   output logic              irq_out,
   output logic [BASE_W-1:0] table_base,
   output logic              dir_to_mem,
   output logic              start_pulse,
   output logic              cancel_pulse,
   output logic              ptr_reload
);
   import dma_chan_pkg::*;

   initial begin
      if (BASE_BYTES != 4)
         $error("dma_chan_regs: window layout assumes a 4-byte base");
   end

   logic [WIN_BYTES-1:0]   lane_we;
   logic [WIN_BYTES*8-1:0] lane_wdata;
   logic [WIN_BYTES*8-1:0] win_image;
   logic run_q, dir_q, active_q, irq_flag_q;
   logic [7:0] cmd_byte, sts_byte;

   dma_lane_decode #(.WIN_BYTES(WIN_BYTES), .ACC_BYTES(4)) u_dec (
      .acc_wr     (acc_wr),
      .acc_offset (acc_offset),
      .acc_size   (acc_size),
      .acc_wdata  (acc_wdata),
      .win_image  (win_image),
      .lane_we    (lane_we),
      .lane_wdata (lane_wdata),
      .acc_rdata  (acc_rdata)
   );

   dma_cmd_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_we       (lane_we[CMD_BYTE]),
      .cmd_wbyte    (lane_wdata[8*CMD_BYTE +: 8]),
      .sts_we       (lane_we[STS_BYTE]),
      .sts_wbyte    (lane_wdata[8*STS_BYTE +: 8]),
      .eng_done     (eng_done),
      .dev_irq      (dev_irq),
      .run_q        (run_q),
      .dir_q        (dir_q),
      .active_q     (active_q),
      .irq_flag_q   (irq_flag_q),
      .start_pulse  (start_pulse),
      .cancel_pulse (cancel_pulse),
      .ptr_reload   (ptr_reload)
   );

   dma_base_reg #(.BASE_BYTES(BASE_BYTES), .ALIGN_BITS(ALIGN_BITS)) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_we    (lane_we[WIN_BYTES-1:BASE_BYTE]),
      .byte_wdata (lane_wdata[WIN_BYTES*8-1:8*BASE_BYTE]),
      .base_q     (table_base)
   );

   always_comb begin
      cmd_byte          = '0;
      cmd_byte[RUN_BIT] = run_q;
      cmd_byte[DIR_BIT] = dir_q;
      sts_byte          = '0;
      sts_byte[ACT_BIT] = active_q;
      sts_byte[IRQ_BIT] = irq_flag_q;
      win_image = {table_base, 8'h00, sts_byte, 8'h00, cmd_byte};
      irq_out    = dev_irq;
      dir_to_mem = dir_q;
   end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_wr,
   input logic [2:0]  acc_offset,
   input logic [31:0] acc_wdata,
   input logic        eng_done,
   input logic        dev_irq,
   input logic [31:0] table_base,
   input logic        start_pulse,
   input logic        cancel_pulse,
   input logic        ptr_reload,
   input logic        run_q,
   input logic        active_q,
   input logic        irq_flag_q
);
   logic cmd_hit;
   assign cmd_hit = acc_wr && (acc_offset == 3'd0);

   a_r3_same_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && (acc_wdata[0] == run_q)) |=> (!start_pulse && !cancel_pulse && !ptr_reload));

   a_r4_cancel_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && !acc_wdata[0] && run_q) |=> (cancel_pulse && !active_q));

   a_r5_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && acc_wdata[0] && !run_q && !active_q) |=> (start_pulse && ptr_reload && active_q));

   a_r4_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && cancel_pulse));

   a_r7_irq_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_irq) |=> irq_flag_q);

   a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !cmd_hit) |=> !active_q);

   a_r9_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      table_base[1:0] == 2'b00);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_wr       (acc_wr),
   .acc_offset   (acc_offset),
   .acc_wdata    (acc_wdata),
   .eng_done     (eng_done),
   .dev_irq      (dev_irq),
   .table_base   (table_base),
   .start_pulse  (start_pulse),
   .cancel_pulse (cancel_pulse),
   .ptr_reload   (ptr_reload),
   .run_q        (run_q),
   .active_q     (active_q),
   .irq_flag_q   (irq_flag_q)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_wr = 1'b0;
   logic [2:0]  acc_offset = '0;
   logic [1:0]  acc_size = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        eng_done = 1'b0;
   logic        dev_irq = 1'b0;
   logic        irq_out;
   logic [31:0] table_base;
   logic        dir_to_mem, start_pulse, cancel_pulse, ptr_reload;

   int checks = 0;
   int errors = 0;

   // reference state
   logic        m_run = 0, m_dir = 0, m_act = 0, m_irq = 0, m_prev = 0;
   logic [31:0] m_base = '0;
   logic        e_start, e_cancel, e_load;

   always #4 clk = ~clk;

   dma_chan_regs dut (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_win();
      return {m_base, 8'h00, 5'b0, m_irq, 1'b0, m_act, 8'h00, 4'b0, m_dir, 2'b0, m_run};
   endfunction

   function automatic logic [31:0] exp_read(input logic [2:0] off, input logic [1:0] sz);
      logic [63:0] sh;
      int nb;
      sh = exp_win() >> (8 * off);
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      for (int b = nb; b < 4; b++) sh[8*b +: 8] = 8'h00;
      return sh[31:0];
   endfunction

   // apply one clock of stimulus, update the reference model, check pulses and readback
   task automatic step(input logic wr, input logic [2:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input logic irqv, input logic done,
                       input string req);
      logic [63:0] wide;
      logic [7:0]  wb [8];
      logic        we [8];
      logic        rise;
      int nb;
      @(negedge clk);
      acc_wr = wr; acc_offset = off; acc_size = sz; acc_wdata = wd;
      dev_irq = irqv; eng_done = done;
      @(posedge clk);
      #1;
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      wide = {32'h0, wd} << (8 * off);
      for (int i = 0; i < 8; i++) begin
         we[i] = wr && (i >= off) && (i < off + nb);
         wb[i] = wide[8*i +: 8];
      end
      rise = irqv && !m_prev;
      m_prev = irqv;
      e_start = 0; e_cancel = 0; e_load = 0;
      if (done) m_act = 0;
      if (we[0]) begin
         if (wb[0][0] != m_run) begin
            if (!wb[0][0]) begin e_cancel = 1; m_act = 0; end
            else begin
               e_load = 1;
               if (!(m_act && !done)) begin e_start = !m_act; m_act = 1; end
            end
         end
         m_run = wb[0][0];
         m_dir = wb[0][3];
      end
      if (we[2] && wb[2][2]) m_irq = 0;
      if (rise) m_irq = 1;
      for (int i = 4; i < 8; i++) if (we[i]) m_base[8*(i-4) +: 8] = wb[i];
      m_base[1:0] = 2'b00;
      check({req, " R3 R4 R5 pulses"}, {61'b0, start_pulse, cancel_pulse, ptr_reload},
            {61'b0, e_start, e_cancel, e_load});
      acc_wr = 0; eng_done = 0;
      acc_offset = 3'd0; acc_size = 2'd2; #1;
      check({req, " R2 R8 low word"}, acc_rdata, exp_read(3'd0, 2'd2));
      acc_offset = 3'd4; #1;
      check({req, " R9 base word"}, acc_rdata, exp_read(3'd4, 2'd2));
      check({req, " R7 irq_out"}, irq_out, irqv);
      check({req, " R2 dir"}, dir_to_mem, m_dir);
   endtask

   task automatic rd_check(input logic [2:0] off, input logic [1:0] sz, input string req);
      @(negedge clk);
      acc_offset = off; acc_size = sz; #1;
      check(req, acc_rdata, exp_read(off, sz));
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      acc_offset = 3'd0; acc_size = 2'd2; #1;
      check("R1 low word", acc_rdata, 32'h0);
      acc_offset = 3'd4; #1;
      check("R1 base", acc_rdata, 32'h0);
      check("R1 pulses", {start_pulse, cancel_pulse, ptr_reload, dir_to_mem}, 4'b0);
      @(negedge clk); rst_n = 1'b1;

      step(1, 3'd0, 2'd0, 32'hFF, 0, 0, "R2 R5 start");       // stores 0x09
      step(1, 3'd0, 2'd0, 32'h09, 0, 0, "R3 repeat run");
      step(1, 3'd0, 2'd0, 32'h01, 0, 1, "R6 done with same run");
      step(1, 3'd0, 2'd0, 32'h00, 0, 0, "R4 cancel");
      step(1, 3'd0, 2'd0, 32'h01, 0, 0, "R5 restart");
      step(1, 3'd0, 2'd0, 32'h00, 0, 1, "R4 R6 cancel with done");
      step(1, 3'd0, 2'd0, 32'h01, 0, 1, "R6 start beats done");
      step(0, 3'd0, 2'd0, 32'h0, 1, 0, "R7 irq rise");
      step(0, 3'd0, 2'd0, 32'h0, 1, 0, "R7 irq steady high");
      step(1, 3'd2, 2'd0, 32'h00, 1, 0, "R8 write zero keeps");
      step(1, 3'd2, 2'd0, 32'hFB, 1, 0, "R8 other bits ignored");
      step(1, 3'd2, 2'd0, 32'h04, 1, 0, "R8 clear");
      step(1, 3'd2, 2'd0, 32'h04, 0, 0, "R7 low level");
      step(1, 3'd2, 2'd0, 32'h04, 1, 0, "R8 rise beats clear");
      step(1, 3'd4, 2'd0, 32'hFF, 0, 0, "R9 byte write low");
      step(1, 3'd6, 2'd1, 32'hABCD, 0, 0, "R9 half write high");
      step(1, 3'd5, 2'd0, 32'h77, 0, 0, "R9 middle byte");
      step(1, 3'd4, 2'd2, 32'h1234_5677, 0, 0, "R9 full write");
      step(1, 3'd7, 2'd2, 32'hDEAD_BE99, 0, 0, "R10 write past end");
      rd_check(3'd5, 2'd0, "R10 byte read");
      rd_check(3'd6, 2'd3, "R10 size code 3 past end");
      rd_check(3'd1, 2'd1, "R10 zero gap bytes");
      step(1, 3'd0, 2'd2, 32'h0004_0008, 0, 0, "R11 combined cmd status");

      for (int n = 0; n < 400; n++) begin
         logic [2:0] off;
         off = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 3) == 0) off = 3'd0;
         step($urandom_range(0, 1) == 1, off, 2'($urandom_range(0, 3)), $urandom,
              $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0, "random");
         rd_check(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "R10 random read");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule